// File: doc/BRIEF.md
# Dual-Clock Two-Port Synchronous Memory

This block is a behavioural model of a synchronous memory with one write port and one read port. Each port has its own clock, its own active-low enable and its own address bus, so a producer in one clock domain can fill the array while a consumer in another drains it. The array holds 1024 words of 22 bits. Each 10-bit address is split into a row field and a column field. Words are stored in one bank per column, and each bank is indexed by row.

A write command is captured on a rising edge of the write clock and committed to the array on the next write-clock edge. A read command is captured on a rising edge of the read clock. On the following read-clock edge the addressed word is loaded into a registered output. That output changes only when a read completes. Writes never reach it, and it holds the last read result while no read is in progress. When the write commit and the read completion fall on the same edge, the read returns the data that was in the array before that write. Array contents are undefined after reset, so a user must write a location before reading it.

Top module: `dpm_top`

## Requirements
- R1: While the read-side reset is high on a read-clock edge, the read output is loaded with zero. Pending read and write commands are discarded.
- R2: A write with `wr_en_n` low at a write-clock edge stores `wr_data` at `wr_addr`. A later read of that address returns the stored word.
- R3: A write-clock edge with `wr_en_n` high leaves every stored word unchanged, whatever values `wr_addr` and `wr_data` carry.
- R4: A read with `rd_en_n` low, captured at read-clock edge k, drives the addressed word onto `rd_data` after edge k+1 and not earlier.
- R5: When no read was captured at edge k, `rd_data` after edge k+1 equals its value after edge k.
- R6: Write activity never changes `rd_data`.
- R7: With both clocks edge-aligned, a read captured on the same edge as a write to the same address returns the old word. A read captured one edge later returns the new word.
- R8: Address bits [9:2] select the row and bits [1:0] select the column. All 1024 addresses, including 0 and 1023, hold independent words.
- R9: All 22 data bits are stored and returned unaltered, including all-ones and alternating patterns.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-port clock |
| wr_rst | input | 1 | Synchronous active-high reset, write domain |
| wr_en_n | input | 1 | Active-low write enable |
| wr_addr | input | 10 | Write address: row in [9:2], column in [1:0] |
| wr_data | input | 22 | Write data |
| rd_clk | input | 1 | Read-port clock |
| rd_rst | input | 1 | Synchronous active-high reset, read domain |
| rd_en_n | input | 1 | Active-low read enable |
| rd_addr | input | 10 | Read address: row in [9:2], column in [1:0] |
| rd_data | output | 22 | Registered read data, held between reads |

## Verification
The bench targets the same-edge read/write collision. A design that forwarded write data would return the new word where the old one is required, and a design with an extra stage would return stale data one read too long. It checks `rd_data` on every cycle, including cycles with only writes or nothing at all. This catches an output that follows the write bus or clears itself when idle. It also drives garbage address and data with the write enable high, which exposes a design that ignores the enable. Reads of the extreme addresses and of every column catch swapped or truncated row and column fields.

// File: rtl/dpm_pkg.sv
package dpm_pkg;
    parameter int ROW_W  = 8;
    parameter int COL_W  = 2;
    parameter int DATA_W = 22;

    localparam int ADDR_W = ROW_W + COL_W;
    localparam int ROWS   = 1 << ROW_W;
    localparam int COLS   = 1 << COL_W;
    localparam int WORDS  = ROWS * COLS;

    typedef logic [ROW_W-1:0]  row_t;
    typedef logic [COL_W-1:0]  col_t;
    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] word_t;

    typedef struct packed {
        logic  live;
        row_t  row;
        col_t  col;
        word_t data;
    } wr_cmd_t;

    typedef struct packed {
        logic live;
        row_t row;
        col_t col;
    } rd_cmd_t;

    function automatic row_t addr_row(input addr_t a);
        return a[ADDR_W-1:COL_W];
    endfunction

    function automatic col_t addr_col(input addr_t a);
        return a[COL_W-1:0];
    endfunction
endpackage

// File: rtl/dpm_wr_port.sv
module dpm_wr_port
    import dpm_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    en_n,
    input  addr_t   addr,
    input  word_t   data,
    output wr_cmd_t cmd
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cmd <= '0;
        end else begin
            cmd.live <= ~en_n;
            cmd.row  <= addr_row(addr);
            cmd.col  <= addr_col(addr);
            cmd.data <= data;
        end
    end
endmodule

// File: rtl/dpm_rd_port.sv
module dpm_rd_port
    import dpm_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    en_n,
    input  addr_t   addr,
    output rd_cmd_t cmd
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cmd <= '0;
        end else begin
            cmd.live <= ~en_n;
            cmd.row  <= addr_row(addr);
            cmd.col  <= addr_col(addr);
        end
    end
endmodule

// File: rtl/dpm_col_bank.sv
module dpm_col_bank
    import dpm_pkg::*;
(
    input  logic  wclk,
    input  logic  we,
    input  row_t  wrow,
    input  word_t wdata,
    input  row_t  rrow,
    output word_t rword
);
    word_t cells [ROWS];

    always_ff @(posedge wclk) begin
        if (we) begin
            cells[wrow] <= wdata;
        end
    end

    assign rword = cells[rrow];
endmodule

// File: rtl/dpm_rd_out.sv
module dpm_rd_out
    import dpm_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  rd_cmd_t cmd,
    input  word_t   words [COLS],
    output word_t   q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (cmd.live) begin
            q <= words[cmd.col];
        end
    end
endmodule

// File: rtl/dpm_top.sv
module dpm_top
    import dpm_pkg::*;
(
    input  logic              wr_clk,
    input  logic              wr_rst,
    input  logic              wr_en_n,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_clk,
    input  logic              rd_rst,
    input  logic              rd_en_n,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    wr_cmd_t wcmd;
    rd_cmd_t rcmd;
    word_t   bank_words [COLS];
    logic    wr_pending;
    logic    rd_pending;

    assign wr_pending = wcmd.live;
    assign rd_pending = rcmd.live;

    dpm_wr_port u_wport (
        .clk  (wr_clk),
        .rst  (wr_rst),
        .en_n (wr_en_n),
        .addr (wr_addr),
        .data (wr_data),
        .cmd  (wcmd)
    );

    dpm_rd_port u_rport (
        .clk  (rd_clk),
        .rst  (rd_rst),
        .en_n (rd_en_n),
        .addr (rd_addr),
        .cmd  (rcmd)
    );

    for (genvar c = 0; c < COLS; c++) begin : g_bank
        logic bank_we;
        assign bank_we = wcmd.live && (wcmd.col == col_t'(c));

        dpm_col_bank u_bank (
            .wclk  (wr_clk),
            .we    (bank_we),
            .wrow  (wcmd.row),
            .wdata (wcmd.data),
            .rrow  (rcmd.row),
            .rword (bank_words[c])
        );
    end

    dpm_rd_out u_out (
        .clk   (rd_clk),
        .rst   (rd_rst),
        .cmd   (rcmd),
        .words (bank_words),
        .q     (rd_data)
    );
endmodule

// File: rtl/dpm_top_chk.sv
module dpm_top_chk
    import dpm_pkg::*;
(
    input logic              wr_clk,
    input logic              wr_rst,
    input logic              wr_en_n,
    input logic              wr_pending,
    input logic              rd_clk,
    input logic              rd_rst,
    input logic              rd_en_n,
    input logic              rd_pending,
    input logic [DATA_W-1:0] rd_data
);
    // R1: reset clears the output register
    p_reset_clears_r1: assert property (@(posedge rd_clk)
        rd_rst |=> (rd_data == '0));

    // R2: an enabled write is taken into the commit stage
    p_write_taken_r2: assert property (@(posedge wr_clk) disable iff (wr_rst)
        !wr_en_n |=> wr_pending);

    // R3: a disabled write cycle commits nothing
    p_write_ignored_r3: assert property (@(posedge wr_clk) disable iff (wr_rst)
        wr_en_n |=> !wr_pending);

    // R4: an enabled read is taken into the capture stage
    p_read_taken_r4: assert property (@(posedge rd_clk) disable iff (rd_rst)
        !rd_en_n |=> rd_pending);

    // R5: without a captured read the output holds its value
    p_hold_r5: assert property (@(posedge rd_clk) disable iff (rd_rst)
        !rd_pending |=> $stable(rd_data));
endmodule

bind dpm_top dpm_top_chk u_chk (
    .wr_clk     (wr_clk),
    .wr_rst     (wr_rst),
    .wr_en_n    (wr_en_n),
    .wr_pending (wr_pending),
    .rd_clk     (rd_clk),
    .rd_rst     (rd_rst),
    .rd_en_n    (rd_en_n),
    .rd_pending (rd_pending),
    .rd_data    (rd_data)
);

// File: tb/dpm_top_bench.sv
`timescale 1ns/1ps
module dpm_top_bench;
    import dpm_pkg::*;

    logic        wr_clk = 1'b0, rd_clk = 1'b0;
    logic        wr_rst = 1'b1, rd_rst = 1'b1;
    logic        wr_en_n = 1'b1, rd_en_n = 1'b1;
    addr_t       wr_addr = '0, rd_addr = '0;
    word_t       wr_data = '0;
    word_t       rd_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Reference store and two-deep expectation pipe for read results
    word_t model [WORDS];
    word_t exp_out = '0;
    bit    p1_v = 1'b0, p2_v = 1'b0;
    word_t p1_d = '0, p2_d = '0;
    string p1_t = "", p2_t = "";

    dpm_top u_dpm_top (
        .wr_clk  (wr_clk),
        .wr_rst  (wr_rst),
        .wr_en_n (wr_en_n),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_clk  (rd_clk),
        .rd_rst  (rd_rst),
        .rd_en_n (rd_en_n),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    // Both ports at 200 MHz with aligned edges, so collisions are deterministic
    always #2.5 wr_clk = ~wr_clk;
    always #2.5 rd_clk = ~rd_clk;

    task automatic check(input string tag, input word_t act, input word_t exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic word_t pattern(input int i);
        return word_t'((i * 32'h9E37) ^ (i << 11) ^ 32'h155);
    endfunction

    // One bench cycle: check output, drive ports, advance the model.
    // A read driven in cycle i shows on rd_data when sampled in cycle i+2.
    task automatic step(input bit do_w, input addr_t wa, input word_t wd,
                        input bit do_r, input addr_t ra, input string rtag);
        @(negedge wr_clk);
        if (p2_v) begin
            exp_out = p2_d;
            check(p2_t, rd_data, exp_out);
        end else begin
            check(do_w ? "R6 write-only cycle" : "R5 idle hold", rd_data, exp_out);
        end
        p2_v = p1_v; p2_d = p1_d; p2_t = p1_t;
        p1_v = do_r; p1_d = model[ra]; p1_t = rtag;
        wr_en_n = ~do_w; wr_addr = wa; wr_data = wd;
        rd_en_n = ~do_r; rd_addr = ra;
        if (do_w) model[wa] = wd;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, '0, '0, 1'b0, '0, "");
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(posedge wr_clk);
        @(negedge wr_clk);
        check("R1 reset output", rd_data, '0);
        wr_rst = 1'b0; rd_rst = 1'b0;
        idle(2);

        // R2 / R8: fill every location, output must stay at reset value (R6)
        for (int i = 0; i < WORDS; i++) step(1'b1, addr_t'(i), pattern(i), 1'b0, '0, "");
        idle(2);

        // R8: extreme addresses and every column of one row
        step(1'b0, '0, '0, 1'b1, addr_t'(0), "R8 address 0");
        step(1'b0, '0, '0, 1'b1, addr_t'(WORDS-1), "R8 address 1023");
        for (int c = 0; c < COLS; c++)
            step(1'b0, '0, '0, 1'b1, addr_t'(12'h2A4 + c), "R8 column select");
        idle(3);

        // R3: disabled write with garbage must not alter address 5
        step(1'b0, addr_t'(5), ~model[5], 1'b0, '0, "");
        idle(1);
        step(1'b0, '0, '0, 1'b1, addr_t'(5), "R3 disabled write");
        idle(3);

        // R9: full-width patterns
        step(1'b1, addr_t'(77), {DATA_W{1'b1}}, 1'b0, '0, "");
        step(1'b1, addr_t'(78), word_t'(22'h2AAAAA), 1'b0, '0, "");
        idle(1);
        step(1'b0, '0, '0, 1'b1, addr_t'(77), "R9 all ones");
        step(1'b0, '0, '0, 1'b1, addr_t'(78), "R9 alternating");
        idle(3);

        // R7: same-edge collision returns old data, next edge returns new
        step(1'b1, addr_t'(300), word_t'(22'h0BEEF1), 1'b1, addr_t'(300), "R7 collision old data");
        step(1'b0, '0, '0, 1'b1, addr_t'(300), "R7 read after write new data");
        idle(3);

        // R4: back-to-back reads with differing data
        step(1'b0, '0, '0, 1'b1, addr_t'(10), "R4 read latency");
        step(1'b0, '0, '0, 1'b1, addr_t'(11), "R4 read latency");
        idle(3);

        // Random mix, addresses often confined to a small window to hit R7
        for (int i = 0; i < 4000; i++) begin
            bit    w  = $urandom_range(1, 0) == 1;
            bit    r  = $urandom_range(1, 0) == 1;
            bit    nr = $urandom_range(3, 0) != 0;
            addr_t wa = nr ? addr_t'($urandom_range(7, 0)) : addr_t'($urandom);
            addr_t ra = nr ? addr_t'($urandom_range(7, 0)) : addr_t'($urandom);
            step(w, wa, word_t'($urandom), r, ra, "R4 random read");
        end
        idle(3);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule